// File: doc/BRIEF.md
# Thread Interrupt Context Register File

This block holds the interrupt management context of one hardware thread. The context is split into four rings of sixteen bytes each: ring 0 carries user event state, ring 1 the OS context, ring 2 the hypervisor pool context and ring 3 the physical thread context. Software reaches the rings through a byte-wide access port whose address selects one of four pages. The same registers sit behind every page, but each page grants a different privilege view. Page 0 is the hardware view and can reach everything. Pages 1, 2 and 3 (hypervisor, OS, user) each see a smaller part.

Every ring has three priority registers: a pending bitmap, a current priority mask and an acknowledge byte. Eight priority levels are active, 0 being the most favoured; 0xFF is the least-favoured value. A single-cycle present input marks a priority pending on a ring. The OS ring drives `os_irq` and the physical ring drives `hv_irq`; each output is high while the ring has a pending priority more favoured than its mask. Reading the acknowledge byte accepts the interrupt. The physical ring also exposes the thread identity word `(block << 19) | index` as read-only bytes.

The access port is valid/ready. A request is taken on a clock edge where `req_valid` and `req_ready` are both high. Exactly one response follows with `rsp_valid` in the next cycle. The response is held, with its data stable, until `rsp_ready` is seen high. `req_ready` is high whenever no response is held, or when the held response is being consumed in the same cycle, so at most one response is ever outstanding.

Top module: `tctx_regfile`

## Requirements
- R1: After reset, both interrupt outputs are low and `req_ready` is high. Every pending bitmap reads 0x00 and every current priority mask reads 0x00.
- R2: Address bits [7:6] select the page, bits [5:4] the ring and bits [3:0] the byte offset. Page 0 reaches rings 0-3, page 1 rings 1-3, page 2 rings 0-1 and page 3 ring 0 only. A read of a ring the page cannot reach returns 0x00, and a write to such a ring, or a read of its acknowledge byte, changes nothing.
- R3: A cycle with `present_valid` high and `present_prio` in 0..7 sets bit `present_prio` of the pending bitmap (offset 0) of ring `present_ring`. A present with a priority of 8 or more is ignored.
- R4: Let the most favoured pending priority of a ring be its lowest set bitmap bit. `os_irq` is high exactly while ring 1 has a set bit numerically below its mask (offset 1), and `hv_irq` does the same for ring 3. Rings 0 and 2 drive neither output. Outputs follow the cycle after the change that causes them.
- R5: When the ring's output condition holds, a read of the acknowledge byte (offset 2) returns the most favoured pending priority. The same read clears that bitmap bit and loads the mask with that priority.
- R6: When the ring's output condition does not hold, a read of the acknowledge byte returns 0xFF and leaves the bitmap and the mask unchanged.
- R7: A mask write of 0..7 or 0xFF is stored. A mask write of 8..0xFE is ignored. A mask of 0xFF lets every pending priority through.
- R8: Ring 3 offsets 4..7 read the identity word `{id_block, id_index}` (block above a 19-bit index), most significant byte at offset 4. Writes to those offsets are ignored.
- R9: Each accepted request yields one response in the next cycle. Write responses carry 0x00. While `rsp_valid` is high and `rsp_ready` is low, `req_ready` is low, `rsp_rdata` holds, and no new request takes effect.
- R10: If a present and an acknowledge hit the same ring and priority in one cycle, the acknowledge returns that priority and loads it into the mask, and the pending bit ends up set.
- R11: Offsets 3..15, other than the identity bytes of ring 3, are plain byte storage that reads back the last value written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Access request valid |
| req_ready | output | 1 | Access request can be taken |
| req_addr | input | 8 | Page, ring and byte offset |
| req_write | input | 1 | 1 = write, 0 = read |
| req_wdata | input | 8 | Write data |
| rsp_valid | output | 1 | Response valid |
| rsp_ready | input | 1 | Response consumer ready |
| rsp_rdata | output | 8 | Read data (0x00 for writes) |
| present_valid | input | 1 | Single-cycle pending-priority strobe |
| present_ring | input | 2 | Ring that receives the priority |
| present_prio | input | 8 | Priority to mark pending |
| id_block | input | BLK_W | Thread identity block number |
| id_index | input | IDX_W | Thread identity index |
| os_irq | output | 1 | OS ring interrupt |
| hv_irq | output | 1 | Physical ring (hypervisor) interrupt |

## Verification
A request taken at a rising edge has its response, its register updates and any change on `os_irq` or `hv_irq` visible after that same edge, one cycle from the drive. A present strobe likewise lands in the bitmap and the outputs one edge after it is driven. The bench drives all inputs on falling edges and samples on the next falling edge, so each check sees exactly the one edge that should have acted. Under back-pressure it samples over several stalled cycles to show that nothing moves until `rsp_ready` returns.

// File: rtl/tctx_pkg.sv
package tctx_pkg;
  localparam int RINGS      = 4;
  localparam int RING_BYTES = 16;
  localparam int LEVELS     = 8;
  localparam int RING_W     = $clog2(RINGS);
  localparam int OFF_W      = $clog2(RING_BYTES);
  localparam int LVL_W      = $clog2(LEVELS);
  localparam int ADDR_W     = 2 + RING_W + OFF_W;

  typedef logic [7:0] byte_t;

  localparam byte_t PRIO_NONE = 8'hFF;

  localparam int OFF_PEND   = 0;
  localparam int OFF_MASK   = 1;
  localparam int OFF_ACK    = 2;
  localparam int OFF_STORE  = 3;
  localparam int OFF_ID_LO  = 4;
  localparam int OFF_ID_HI  = 7;

  function automatic logic mask_legal(byte_t v);
    return (v < byte_t'(LEVELS)) || (v == PRIO_NONE);
  endfunction
endpackage

// File: rtl/tctx_prio_enc.sv
module tctx_prio_enc #(
  parameter int N  = 8,
  parameter int IW = $clog2(N)
) (
  input  logic [N-1:0]  bits,
  output logic          found,
  output logic [IW-1:0] idx
);
  always_comb begin
    found = 1'b0;
    idx   = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (bits[i]) begin
        found = 1'b1;
        idx   = IW'(i);
      end
    end
  end
endmodule

// File: rtl/tctx_page_gate.sv
module tctx_page_gate
  import tctx_pkg::*;
(
  input  logic [1:0]        page,
  input  logic [RING_W-1:0] ring,
  output logic              allow
);
  always_comb begin
    unique case (page)
      2'd0: allow = 1'b1;
      2'd1: allow = (ring != RING_W'(0));
      2'd2: allow = (ring <= RING_W'(1));
      default: allow = (ring == RING_W'(0));
    endcase
  end
endmodule

// File: rtl/tctx_ring.sv
module tctx_ring
  import tctx_pkg::*;
#(
  parameter bit HAS_ID = 1'b0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              ack_en,
  input  logic [OFF_W-1:0]  off,
  input  byte_t             wdata,
  input  logic [LEVELS-1:0] set_mask,
  input  logic [31:0]       id_word,
  output byte_t             rd_data,
  output logic [LEVELS-1:0] pend,
  output byte_t             mask,
  output logic              irq
);
  logic [LEVELS-1:0] pend_q, pend_d;
  byte_t             mask_q;
  byte_t             mem_q [RING_BYTES];
  logic              best_found;
  logic [LVL_W-1:0]  best_idx;
  byte_t             best_byte;
  byte_t             ack_val;
  logic              id_off;

  tctx_prio_enc #(.N(LEVELS)) u_enc (
    .bits  (pend_q),
    .found (best_found),
    .idx   (best_idx)
  );

  assign best_byte = byte_t'(best_idx);
  assign irq       = best_found && (best_byte < mask_q);
  assign ack_val   = irq ? best_byte : PRIO_NONE;
  assign id_off    = HAS_ID && (int'(off) >= OFF_ID_LO) && (int'(off) <= OFF_ID_HI);

  always_comb begin
    pend_d = pend_q;
    if (wr_en && (int'(off) == OFF_PEND)) pend_d = wdata[LEVELS-1:0];
    if (ack_en && irq) pend_d[best_idx] = 1'b0;
    pend_d = pend_d | set_mask;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= '0;
      mask_q <= '0;
    end else begin
      pend_q <= pend_d;
      if (wr_en && (int'(off) == OFF_MASK) && mask_legal(wdata)) mask_q <= wdata;
      else if (ack_en && irq) mask_q <= best_byte;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < RING_BYTES; i++) mem_q[i] <= '0;
    end else if (wr_en && (int'(off) >= OFF_STORE) && !id_off) begin
      mem_q[off] <= wdata;
    end
  end

  always_comb begin
    if (int'(off) == OFF_PEND)      rd_data = byte_t'(pend_q);
    else if (int'(off) == OFF_MASK) rd_data = mask_q;
    else if (int'(off) == OFF_ACK)  rd_data = ack_val;
    else if (id_off)                rd_data = id_word[8*(OFF_ID_HI - int'(off)) +: 8];
    else                            rd_data = mem_q[off];
  end

  assign pend = pend_q;
  assign mask = mask_q;
endmodule

// File: rtl/tctx_regfile.sv
module tctx_regfile
  import tctx_pkg::*;
#(
  parameter int BLK_W = 4,
  parameter int IDX_W = 19
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic              req_write,
  input  logic [7:0]        req_wdata,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic [7:0]        rsp_rdata,
  input  logic              present_valid,
  input  logic [RING_W-1:0] present_ring,
  input  logic [7:0]        present_prio,
  input  logic [BLK_W-1:0]  id_block,
  input  logic [IDX_W-1:0]  id_index,
  output logic              os_irq,
  output logic              hv_irq
);
  localparam int ID_PAD = 32 - BLK_W - IDX_W;
  localparam int RING_OS = 1;
  localparam int RING_HV = 3;

  logic [1:0]        a_page;
  logic [RING_W-1:0] a_ring;
  logic [OFF_W-1:0]  a_off;
  logic              allow;
  logic              accept;
  logic              rsp_valid_q;
  byte_t             rsp_data_q;
  logic [31:0]       id_word;
  byte_t             rd_vec   [RINGS];
  logic [RINGS-1:0]  irq_vec;
  logic [RINGS*LEVELS-1:0] pend_flat;
  logic [RINGS*8-1:0]      mask_flat;

  assign {a_page, a_ring, a_off} = req_addr;
  assign id_word   = {{ID_PAD{1'b0}}, id_block, id_index};
  assign req_ready = !rsp_valid_q || rsp_ready;
  assign accept    = req_valid && req_ready;

  tctx_page_gate u_gate (
    .page  (a_page),
    .ring  (a_ring),
    .allow (allow)
  );

  for (genvar r = 0; r < RINGS; r++) begin : g_ring
    logic              hit;
    logic              wr_en;
    logic              ack_en;
    logic [LEVELS-1:0] set_mask;
    logic [LEVELS-1:0] pend;
    byte_t             mask;

    assign hit    = accept && allow && (a_ring == RING_W'(r));
    assign wr_en  = hit && req_write;
    assign ack_en = hit && !req_write && (int'(a_off) == OFF_ACK);

    always_comb begin
      set_mask = '0;
      if (present_valid && (present_ring == RING_W'(r)) && (present_prio < 8'(LEVELS)))
        set_mask[present_prio[LVL_W-1:0]] = 1'b1;
    end

    tctx_ring #(.HAS_ID(r == RING_HV)) u_ring (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_en    (wr_en),
      .ack_en   (ack_en),
      .off      (a_off),
      .wdata    (req_wdata),
      .set_mask (set_mask),
      .id_word  (id_word),
      .rd_data  (rd_vec[r]),
      .pend     (pend),
      .mask     (mask),
      .irq      (irq_vec[r])
    );

    assign pend_flat[r*LEVELS +: LEVELS] = pend;
    assign mask_flat[r*8 +: 8]           = mask;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid_q <= 1'b0;
      rsp_data_q  <= '0;
    end else if (accept) begin
      rsp_valid_q <= 1'b1;
      rsp_data_q  <= (!req_write && allow) ? rd_vec[a_ring] : 8'h00;
    end else if (rsp_ready) begin
      rsp_valid_q <= 1'b0;
    end
  end

  assign rsp_valid = rsp_valid_q;
  assign rsp_rdata = rsp_data_q;
  assign os_irq    = irq_vec[RING_OS];
  assign hv_irq    = irq_vec[RING_HV];
endmodule

// File: rtl/tctx_regfile_chk.sv
module tctx_regfile_chk
  import tctx_pkg::*;
(
  input logic                     clk,
  input logic                     rst_n,
  input logic                     req_valid,
  input logic                     req_ready,
  input logic                     rsp_valid,
  input logic                     rsp_ready,
  input logic [7:0]               rsp_rdata,
  input logic                     present_valid,
  input logic [RING_W-1:0]        present_ring,
  input logic [7:0]               present_prio,
  input logic [RINGS*LEVELS-1:0]  pend_flat,
  input logic [RINGS*8-1:0]       mask_flat,
  input logic [RINGS-1:0]         irq_vec
);
  logic [RING_W+LVL_W-1:0] psel;
  assign psel = {present_ring, present_prio[LVL_W-1:0]};

  p_rsp_after_accept_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> rsp_valid);

  p_rsp_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_rdata)));

  p_stall_freezes_mask_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !req_ready |=> $stable(mask_flat));

  p_present_sets_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (present_valid && (present_prio < 8'(LEVELS))) |=> pend_flat[$past(psel)]);

  p_irq_needs_pending_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_vec[0] -> |pend_flat[0*LEVELS +: LEVELS]) &&
    (irq_vec[1] -> |pend_flat[1*LEVELS +: LEVELS]) &&
    (irq_vec[2] -> |pend_flat[2*LEVELS +: LEVELS]) &&
    (irq_vec[3] -> |pend_flat[3*LEVELS +: LEVELS]));

  for (genvar r = 0; r < RINGS; r++) begin : g_mask
    p_mask_legal_r7: assert property (@(posedge clk) disable iff (!rst_n)
      mask_legal(mask_flat[r*8 +: 8]));
  end
endmodule

bind tctx_regfile tctx_regfile_chk u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .req_valid     (req_valid),
  .req_ready     (req_ready),
  .rsp_valid     (rsp_valid),
  .rsp_ready     (rsp_ready),
  .rsp_rdata     (rsp_rdata),
  .present_valid (present_valid),
  .present_ring  (present_ring),
  .present_prio  (present_prio),
  .pend_flat     (pend_flat),
  .mask_flat     (mask_flat),
  .irq_vec       (irq_vec)
);

// File: tb/tctx_regfile_tb_top.sv
`timescale 1ns/1ps
module tctx_regfile_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       req_valid = 1'b0;
  logic       req_ready;
  logic [7:0] req_addr = '0;
  logic       req_write = 1'b0;
  logic [7:0] req_wdata = '0;
  logic       rsp_valid;
  logic       rsp_ready = 1'b1;
  logic [7:0] rsp_rdata;
  logic       present_valid = 1'b0;
  logic [1:0] present_ring = '0;
  logic [7:0] present_prio = '0;
  logic [3:0] id_block = 4'hA;
  logic [18:0] id_index = 19'h12345;
  logic       os_irq, hv_irq;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  tctx_regfile dut_i (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr),
    .req_write(req_write), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_rdata(rsp_rdata),
    .present_valid(present_valid), .present_ring(present_ring), .present_prio(present_prio),
    .id_block(id_block), .id_index(id_index),
    .os_irq(os_irq), .hv_irq(hv_irq)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic xfer(input logic [1:0] pg, input logic [1:0] rg, input logic [3:0] off,
                      input logic wr, input logic [7:0] wd, output logic [7:0] rd);
    @(negedge clk);
    req_valid = 1'b1; req_addr = {pg, rg, off}; req_write = wr; req_wdata = wd;
    @(negedge clk);
    req_valid = 1'b0;
    rd = rsp_rdata;
  endtask

  task automatic wr8(input logic [1:0] pg, input logic [1:0] rg, input logic [3:0] off,
                     input logic [7:0] wd);
    logic [7:0] unused_rd;
    xfer(pg, rg, off, 1'b1, wd, unused_rd);
  endtask

  task automatic rd8(input logic [1:0] pg, input logic [1:0] rg, input logic [3:0] off,
                     output logic [7:0] rd);
    xfer(pg, rg, off, 1'b0, 8'h00, rd);
  endtask

  task automatic present(input logic [1:0] rg, input logic [7:0] pr);
    @(negedge clk);
    present_valid = 1'b1; present_ring = rg; present_prio = pr;
    @(negedge clk);
    present_valid = 1'b0;
  endtask

  task automatic t_reset();
    logic [7:0] d;
    chk("R1 os_irq", 32'(os_irq), 0);
    chk("R1 hv_irq", 32'(hv_irq), 0);
    chk("R1 req_ready", 32'(req_ready), 1);
    rd8(2'd0, 2'd1, 4'd0, d); chk("R1 pending", 32'(d), 0);
    rd8(2'd0, 2'd3, 4'd1, d); chk("R1 mask", 32'(d), 0);
  endtask

  task automatic t_pages();
    logic [7:0] d;
    logic ok;
    for (int r = 0; r < 4; r++) wr8(2'd0, 2'(r), 4'd8, 8'h10 + 8'(r));
    for (int p = 0; p < 4; p++) begin
      for (int r = 0; r < 4; r++) begin
        ok = (p == 0) || (p == 1 && r != 0) || (p == 2 && r <= 1) || (p == 3 && r == 0);
        rd8(2'(p), 2'(r), 4'd8, d);
        chk("R2 page view", 32'(d), ok ? 32'(8'h10 + 8'(r)) : 0);
      end
    end
    wr8(2'd3, 2'd1, 4'd8, 8'hEE);
    rd8(2'd0, 2'd1, 4'd8, d); chk("R2 denied write", 32'(d), 32'h11);
    wr8(2'd2, 2'd0, 4'd9, 8'h55);
    rd8(2'd0, 2'd0, 4'd9, d); chk("R11 storage", 32'(d), 32'h55);
  endtask

  task automatic t_present();
    logic [7:0] d;
    present(2'd1, 8'd5);
    rd8(2'd0, 2'd1, 4'd0, d); chk("R3 pending set", 32'(d), 32'h20);
    chk("R4 masked by zero", 32'(os_irq), 0);
    present(2'd1, 8'd9);
    rd8(2'd0, 2'd1, 4'd0, d); chk("R3 invalid prio", 32'(d), 32'h20);
  endtask

  task automatic t_irq();
    wr8(2'd2, 2'd1, 4'd1, 8'd6);
    chk("R4 os asserts", 32'(os_irq), 1);
    chk("R4 hv idle", 32'(hv_irq), 0);
    wr8(2'd2, 2'd1, 4'd1, 8'd5);
    chk("R4 equal mask", 32'(os_irq), 0);
    wr8(2'd2, 2'd1, 4'd1, 8'hFF);
    chk("R7 0xFF unmasks", 32'(os_irq), 1);
    present(2'd3, 8'd2);
    chk("R4 hv masked", 32'(hv_irq), 0);
    wr8(2'd1, 2'd3, 4'd1, 8'd3);
    chk("R4 hv asserts", 32'(hv_irq), 1);
    wr8(2'd0, 2'd2, 4'd1, 8'hFF);
    present(2'd2, 8'd0);
    chk("R4 ring2 no pin", 32'({os_irq, hv_irq}), 32'b11);
  endtask

  task automatic t_ack();
    logic [7:0] d;
    present(2'd1, 8'd3);
    rd8(2'd2, 2'd1, 4'd2, d); chk("R5 ack value", 32'(d), 3);
    chk("R5 os drops", 32'(os_irq), 0);
    rd8(2'd0, 2'd1, 4'd0, d); chk("R5 bit cleared", 32'(d), 32'h20);
    rd8(2'd0, 2'd1, 4'd1, d); chk("R5 mask loaded", 32'(d), 3);
    rd8(2'd2, 2'd1, 4'd2, d); chk("R6 empty ack", 32'(d), 32'hFF);
    rd8(2'd0, 2'd1, 4'd0, d); chk("R6 pending kept", 32'(d), 32'h20);
    rd8(2'd0, 2'd1, 4'd1, d); chk("R6 mask kept", 32'(d), 3);
    rd8(2'd3, 2'd1, 4'd2, d); chk("R2 denied ack", 32'(d), 0);
  endtask

  task automatic t_mask();
    logic [7:0] d;
    wr8(2'd2, 2'd1, 4'd1, 8'd8);
    rd8(2'd0, 2'd1, 4'd1, d); chk("R7 reject 8", 32'(d), 3);
    wr8(2'd2, 2'd1, 4'd1, 8'hFE);
    rd8(2'd0, 2'd1, 4'd1, d); chk("R7 reject FE", 32'(d), 3);
    wr8(2'd2, 2'd1, 4'd1, 8'hFF);
    rd8(2'd0, 2'd1, 4'd1, d); chk("R7 accept FF", 32'(d), 32'hFF);
    chk("R7 os back", 32'(os_irq), 1);
  endtask

  task automatic t_ident();
    logic [7:0] d;
    logic [31:0] w;
    w = 0;
    for (int o = 4; o < 8; o++) begin
      rd8(2'd0, 2'd3, 4'(o), d);
      w = {w[23:0], d};
    end
    chk("R8 identity word", w, 32'h0051_2345);
    wr8(2'd0, 2'd3, 4'd5, 8'hFF);
    rd8(2'd1, 2'd3, 4'd5, d); chk("R8 read-only", 32'(d), 32'h51);
    rd8(2'd2, 2'd3, 4'd5, d); chk("R2 id hidden", 32'(d), 0);
  endtask

  task automatic t_stall();
    logic [7:0] d;
    @(negedge clk);
    rsp_ready = 1'b0;
    req_valid = 1'b1; req_addr = {2'd0, 2'd1, 4'd1}; req_write = 1'b0;
    @(negedge clk);
    chk("R9 rsp next cycle", 32'({rsp_valid, rsp_rdata}), 32'h1FF);
    chk("R9 ready low", 32'(req_ready), 0);
    req_write = 1'b1; req_wdata = 8'd6;
    @(negedge clk);
    @(negedge clk);
    chk("R9 held", 32'({rsp_valid, rsp_rdata}), 32'h1FF);
    rsp_ready = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    chk("R9 write rsp", 32'({rsp_valid, rsp_rdata}), 32'h100);
    rd8(2'd0, 2'd1, 4'd1, d); chk("R9 write landed once", 32'(d), 6);
  endtask

  task automatic t_collide();
    logic [7:0] d;
    @(negedge clk);
    req_valid = 1'b1; req_addr = {2'd2, 2'd1, 4'd2}; req_write = 1'b0;
    present_valid = 1'b1; present_ring = 2'd1; present_prio = 8'd5;
    @(negedge clk);
    req_valid = 1'b0; present_valid = 1'b0;
    chk("R10 ack value", 32'(rsp_rdata), 5);
    rd8(2'd0, 2'd1, 4'd0, d); chk("R10 bit survives", 32'(d), 32'h20);
    rd8(2'd0, 2'd1, 4'd1, d); chk("R10 mask", 32'(d), 5);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_pages();
    t_present();
    t_irq();
    t_ack();
    t_mask();
    t_ident();
    t_stall();
    t_collide();
    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end
endmodule